// File: doc/BRIEF.md
# Synchronous serial port register and FIFO controller

This block is the register-side half of a synchronous serial port. A host reaches it through a simple 32-bit register bus that has an address, a write strobe with write data, and a read strobe with read data. The block holds two control words, a clock prescaler byte and an interrupt enable mask. It also holds an eight-entry transmit queue and an eight-entry receive queue of 16-bit words. From the queue fill levels it derives a status word, two raw interrupt conditions and one level interrupt line.

A separate transfer engine moves the words. It takes a word from the transmit queue with a pop strobe while `eng_tx_valid` is high, and it returns the received word with a push strobe. The engine is only offered a word while the port is enabled and the receive queue has room. Because of this rule the receive queue can never overrun. Words are cut to a programmable data size in both directions. A fixed read-only identification window sits at the top of the 4 KiB register space.

Two small state machines drive the behaviour. The bus responder has two states. `BUS_IDLE` drives zero on `bus_rdata`. `BUS_RSP` drives the word captured by a read in the previous cycle. A read strobe moves the responder from either state to `BUS_RSP` (transition *capture*). A cycle with no read strobe moves it back to `BUS_IDLE` (transition *release*). Each queue keeps an occupancy state with three values: `FS_EMPTY`, `FS_PARTIAL` and `FS_FULL`. *fill* moves `FS_EMPTY` to `FS_PARTIAL`. *top* moves `FS_PARTIAL` to `FS_FULL`. *drain* moves `FS_FULL` to `FS_PARTIAL`. *clear* moves `FS_PARTIAL` to `FS_EMPTY`. A queue of depth one moves directly between `FS_EMPTY` and `FS_FULL`.

Top module: `sspc_ctrl`

## Requirements
- R1: After reset both queues are empty, the mask reads 0, the status word (0x0C) reads 0x03, the raw interrupt word (0x18) reads 0x08 and `irq` is low.
- R2: Status bits are: bit0 transmit queue empty, bit1 transmit queue not full, bit2 receive queue not empty, bit3 receive queue full, bit4 busy (the transmit queue holds at least one word). They reflect every push or pop from the cycle after that push or pop.
- R3: A write to the data offset 0x08 appends a word to the transmit queue. If the queue already holds 8 words, the write is dropped.
- R4: A read of offset 0x08 returns the oldest receive word and removes it. If the receive queue is empty, the read returns 0 and changes nothing.
- R5: The data size mask is 2^(n+1)-1, where n is bits [3:0] of control word 0 (offset 0x00). The mask is applied to a word when it enters the transmit queue and when it enters the receive queue.
- R6: Raw interrupt bit2 is set while the receive queue holds 4 or more words. Raw interrupt bit3 is set while the transmit queue holds 4 or fewer words.
- R7: `irq` is high exactly when the raw interrupt word AND the mask (offset 0x14) is non-zero. Offset 0x1C reads that AND.
- R8: Reads at 0xFE0 to 0xFFC return one identification byte per word: 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes there are dropped.
- R9: The prescaler (0x10) keeps only bits [7:0], and offset 0x20 always reads 0. Any other unmapped offset reads 0, and writes to it have no effect.
- R10: `eng_tx_valid` is high only while control word 1 bit1 (enable) is set, the transmit queue is not empty and the receive queue is not full. The engine receives words in the order they were written.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe. It is 0 in any cycle that does not follow a read.
- R12: Control word 0 reads back all 32 written bits. Control word 1 reads back bits [3:0]. Bit0 of control word 1 drives `eng_loopback`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| irq | output | 1 | Level interrupt |
| eng_tx_valid | output | 1 | Transmit word offered to the engine |
| eng_tx_data | output | 16 | Oldest transmit word |
| eng_tx_pop | input | 1 | Engine takes the offered word |
| eng_rx_push | input | 1 | Engine returns a received word |
| eng_rx_data | input | 16 | Received word |
| eng_rx_ready | output | 1 | Receive queue has room |
| eng_enable | output | 1 | Port enable, bit1 of control word 1 |
| eng_loopback | output | 1 | Loopback select, bit0 of control word 1 |

## Verification
The embedded properties check four behaviours on every cycle. A full queue does not change its count when a push comes without a pop. A pop from an empty queue leaves it empty. The occupancy state agrees with the count. Read data never appears without a read strobe in the cycle before. The bench scenarios are needed for the rest. They show the word order through both queues, the data size masking, the interrupt thresholds at 3 and 4 entries, and the transmit stall while the receive queue is full. They also cover the identification bytes and the dropped writes to unmapped or read-only offsets.

// File: rtl/sspc_pkg.sv
package sspc_pkg;
    localparam int BUS_AW = 12;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_CTRL0 = 12'h000;
    localparam logic [BUS_AW-1:0] OFS_CTRL1 = 12'h004;
    localparam logic [BUS_AW-1:0] OFS_DATA  = 12'h008;
    localparam logic [BUS_AW-1:0] OFS_STAT  = 12'h00C;
    localparam logic [BUS_AW-1:0] OFS_PSC   = 12'h010;
    localparam logic [BUS_AW-1:0] OFS_MASK  = 12'h014;
    localparam logic [BUS_AW-1:0] OFS_RAW   = 12'h018;
    localparam logic [BUS_AW-1:0] OFS_MSK   = 12'h01C;
    localparam logic [BUS_AW-1:0] OFS_DMA   = 12'h020;

    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_FULL    = 2'd2
    } fifo_state_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RSP  = 1'b1
    } bus_state_e;
endpackage

// File: rtl/sspc_fifo.sv
module sspc_fifo
    import sspc_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  pop_data,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    fifo_state_e   state_q, state_d;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count_d;
    logic [W-1:0]  mem [DEPTH];
    logic          do_push, do_pop;

    assign do_push = push && (state_q != FS_FULL);
    assign do_pop  = pop  && (state_q != FS_EMPTY);

    always_comb begin
        count_d = count;
        if (do_push && !do_pop)      count_d = count + CW'(1);
        else if (do_pop && !do_push) count_d = count - CW'(1);
    end

    always_comb begin
        if (count_d == '0)                count_d_state: state_d = FS_EMPTY;
        else if (count_d == CW'(DEPTH))   state_d = FS_FULL;
        else                              state_d = FS_PARTIAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_EMPTY;
            count   <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            count   <= count_d;
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_comb begin
        unique case (state_q)
            FS_EMPTY:   begin empty = 1'b1; full = 1'b0; end
            FS_FULL:    begin empty = 1'b0; full = 1'b1; end
            default:    begin empty = 1'b0; full = 1'b0; end
        endcase
    end

    assign pop_data = mem[rd_ptr];

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) && push && !pop |=> count == CW'(DEPTH));
    a_r4_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) && pop && !push |=> count == '0);
    a_r2_state_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FS_EMPTY) == (count == '0)) && ((state_q == FS_FULL) == (count == CW'(DEPTH))));
endmodule

// File: rtl/sspc_id_rom.sv
module sspc_id_rom (
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);
    always_comb begin
        unique case (idx)
            3'd0: id_byte = 8'h22;
            3'd1: id_byte = 8'h10;
            3'd2: id_byte = 8'h04;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    end
endmodule

// File: rtl/sspc_ctrl.sv
module sspc_ctrl
    import sspc_pkg::*;
#(
    parameter int WORD  = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq,
    output logic              eng_tx_valid,
    output logic [WORD-1:0]   eng_tx_data,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [WORD-1:0]   eng_rx_data,
    output logic              eng_rx_ready,
    output logic              eng_enable,
    output logic              eng_loopback
);
    logic [BUS_DW-1:0] ctrl0_q;
    logic [3:0]        ctrl1_q;
    logic [7:0]        psc_q;
    logic [3:0]        imask_q;
    logic [WORD-1:0]   size_mask;
    logic [3:0]        raw_int;
    logic [4:0]        stat;
    logic [CW-1:0]     tx_count, rx_count;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [WORD-1:0]   rx_head;
    logic [7:0]        id_byte;
    logic              id_hit;
    logic [BUS_DW-1:0] rd_val, rdata_q;
    bus_state_e        bus_q, bus_d;

    // Data size mask: bit i kept when i <= ctrl0[3:0]
    for (genvar i = 0; i < WORD; i++) begin : g_mask
        assign size_mask[i] = (5'(i) <= {1'b0, ctrl0_q[3:0]});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
            psc_q   <= '0;
            imask_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                OFS_CTRL0: ctrl0_q <= bus_wdata;
                OFS_CTRL1: ctrl1_q <= bus_wdata[3:0];
                OFS_PSC:   psc_q   <= bus_wdata[7:0];
                OFS_MASK:  imask_q <= bus_wdata[3:0];
                default:   ;
            endcase
        end
    end

    assign eng_enable   = ctrl1_q[1];
    assign eng_loopback = ctrl1_q[0];
    assign eng_tx_valid = eng_enable && !tx_empty && !rx_full;
    assign eng_rx_ready = !rx_full;

    sspc_fifo #(.W(WORD), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(bus_wr && bus_addr == OFS_DATA),
        .push_data(bus_wdata[WORD-1:0] & size_mask),
        .pop(eng_tx_pop && eng_tx_valid),
        .pop_data(eng_tx_data),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    sspc_fifo #(.W(WORD), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_push),
        .push_data(eng_rx_data & size_mask),
        .pop(bus_rd && bus_addr == OFS_DATA),
        .pop_data(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    assign stat    = {tx_count != '0, rx_full, !rx_empty, !tx_full, tx_empty};
    assign raw_int = {tx_count <= CW'(HALF), rx_count >= CW'(HALF), 2'b00};
    assign irq     = |(raw_int & imask_q);

    assign id_hit = (bus_addr[11:5] == 7'h7F) && (bus_addr[1:0] == 2'b00);
    sspc_id_rom u_id (.idx(bus_addr[4:2]), .id_byte(id_byte));

    always_comb begin
        rd_val = '0;
        if (id_hit) begin
            rd_val = {24'd0, id_byte};
        end else begin
            unique case (bus_addr)
                OFS_CTRL0: rd_val = ctrl0_q;
                OFS_CTRL1: rd_val = {28'd0, ctrl1_q};
                OFS_DATA:  rd_val = rx_empty ? '0 : {{(BUS_DW-WORD){1'b0}}, rx_head};
                OFS_STAT:  rd_val = {27'd0, stat};
                OFS_PSC:   rd_val = {24'd0, psc_q};
                OFS_MASK:  rd_val = {28'd0, imask_q};
                OFS_RAW:   rd_val = {28'd0, raw_int};
                OFS_MSK:   rd_val = {28'd0, raw_int & imask_q};
                OFS_DMA:   rd_val = '0;
                default:   rd_val = '0;
            endcase
        end
    end

    // Bus responder: capture on a read strobe, release otherwise
    always_comb begin
        unique case (bus_q)
            BUS_IDLE: bus_d = bus_rd ? BUS_RSP : BUS_IDLE;
            BUS_RSP:  bus_d = bus_rd ? BUS_RSP : BUS_IDLE;
            default:  bus_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q   <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            bus_q   <= bus_d;
            rdata_q <= bus_rd ? rd_val : '0;
        end
    end

    always_comb begin
        unique case (bus_q)
            BUS_RSP:  bus_rdata = rdata_q;
            default:  bus_rdata = '0;
        endcase
    end

    a_r11_rdata_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata != '0 |-> $past(bus_rd));
    a_r9_psc_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == OFS_PSC |=> psc_q == $past(bus_wdata[7:0]));
    a_r10_no_offer_when_rx_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count == CW'(DEPTH) |-> !eng_tx_valid);
endmodule

// File: tb/sspc_ctrl_test.sv
module sspc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq, eng_tx_valid, eng_rx_ready, eng_enable, eng_loopback;
    logic [15:0] eng_tx_data;
    logic        eng_tx_pop = 1'b0;
    logic        eng_rx_push = 1'b0;
    logic [15:0] eng_rx_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    bit rd_seen = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    sspc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_pop(eng_tx_pop),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
        .eng_enable(eng_enable), .eng_loopback(eng_loopback)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare the response that follows each read strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic eng_take(input logic [15:0] exp, input string tag);
        @(negedge clk);
        check({31'd0, eng_tx_valid}, 32'd1, {tag, " valid"});
        check({16'd0, eng_tx_data}, {16'd0, exp}, tag);
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic eng_give(input logic [15:0] d);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    initial begin
        logic [7:0] ids [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check({31'd0, irq}, 32'd0, "R1 irq");
        bus_read(12'h00C, 32'h03, "R1 status");
        bus_read(12'h018, 32'h08, "R1 raw");
        bus_read(12'h014, 32'h00, "R1 mask");
        bus_read(12'h01C, 32'h00, "R1 masked");
        @(negedge clk);
        check(bus_rdata, 32'd0, "R11 idle rdata");

        // R12 control readback
        bus_write(12'h000, 32'hA5C3_000F);
        bus_read(12'h000, 32'hA5C3_000F, "R12 ctrl0");

        // R3 fill transmit queue while disabled
        for (int i = 0; i < 8; i++) bus_write(12'h008, 32'h1230 + i);
        bus_write(12'h008, 32'hDEAD);
        bus_read(12'h00C, 32'h10, "R2 status tx full");
        bus_read(12'h018, 32'h00, "R6 raw tx=8");
        check({31'd0, eng_tx_valid}, 32'd0, "R10 disabled no offer");

        // R7 mask transmit interrupt, enable port
        bus_write(12'h014, 32'h8);
        check({31'd0, irq}, 32'd0, "R7 irq low tx=8");
        bus_write(12'h004, 32'h2);
        for (int i = 0; i < 3; i++) begin
            eng_take(16'h1230 + 16'(i), "R10 tx order");
            eng_give(16'hF000 + 16'(i));
        end
        bus_read(12'h018, 32'h00, "R6 raw tx=5 rx=3");
        eng_take(16'h1233, "R10 tx order");
        eng_give(16'hF003);
        check({31'd0, irq}, 32'd1, "R7 irq high tx=4");
        bus_read(12'h01C, 32'h08, "R7 masked");
        bus_read(12'h018, 32'h0C, "R6 raw tx=4 rx=4");
        bus_read(12'h00C, 32'h16, "R2 status mid");
        for (int i = 4; i < 8; i++) begin
            eng_take(16'h1230 + 16'(i), "R3 tx order no 9th");
            eng_give(16'hF000 + 16'(i));
        end
        bus_read(12'h00C, 32'h0F, "R2 status rx full");
        check({31'd0, eng_rx_ready}, 32'd0, "R10 rx not ready");

        // R10 stall while receive queue full
        bus_write(12'h008, 32'h0055);
        @(negedge clk);
        check({31'd0, eng_tx_valid}, 32'd0, "R10 stall rx full");
        bus_read(12'h00C, 32'h1E, "R2 status stall");

        // R4 drain receive queue in order, then empty read
        for (int i = 0; i < 8; i++) bus_read(12'h008, 32'hF000 + i, "R4 rx order");
        bus_read(12'h008, 32'h0, "R4 empty read");
        bus_read(12'h00C, 32'h12, "R4 status after empty read");
        @(negedge clk);
        check({31'd0, eng_tx_valid}, 32'd1, "R10 offer resumes");

        // R5 data size mask at 8 bits
        bus_write(12'h000, 32'h7);
        eng_take(16'h0055, "R5 stored word");
        eng_give(16'hABCD);
        bus_read(12'h008, 32'hCD, "R5 rx masked");
        bus_write(12'h008, 32'h1234);
        eng_take(16'h0034, "R5 tx masked");

        // R9 prescaler, DMA, unmapped
        bus_write(12'h010, 32'h1FF);
        bus_read(12'h010, 32'hFF, "R9 prescaler");
        bus_read(12'h020, 32'h0, "R9 dma");
        bus_write(12'h024, 32'hFFFF_FFFF);
        bus_read(12'h024, 32'h0, "R9 unmapped");
        bus_read(12'h000, 32'h7, "R9 ctrl0 untouched");

        // R8 identification window
        bus_write(12'hFE0, 32'h0);
        for (int i = 0; i < 8; i++) bus_read(12'hFE0 + 12'(4 * i), {24'd0, ids[i]}, "R8 id");

        // R12 control word 1
        bus_write(12'h004, 32'hF5);
        bus_read(12'h004, 32'h5, "R12 ctrl1");
        check({30'd0, eng_enable, eng_loopback}, 32'h1, "R12 loopback out");

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule